// File: doc/BRIEF.md
# Three-Level Supply Pulse Classifier

This block sits behind two comparators on a sensor's supply line. One flag says the supply is at or above the mid level, about 12.5 to 14 V. The other says it is at or above the high level, about 21 to 27 V. The baseline sits at roughly 5 V.

The block does not react to edges. It measures how long the line stays raised, and how long it holds the high level without a break. When the line drops back to the baseline, it turns the whole excursion into exactly one clean event:
- a mid pulse,
- a high pulse, or
- a blow pulse (a long high-level hold).

It emits nothing if the excursion was too short, or if it came too soon after the previous one.

All durations are given in microseconds. They are turned into clock cycles through the `cyc_per_us` input. The minimum active width, the minimum quiet gap and the minimum blow hold are parameters.

When the supply-present flag drops, the block raises a reset output for the downstream programming logic. It also forgets every partial measurement.

Top module: `supply_pulse_classifier`

## Requirements
- R1: While `rst_n` is low, and on the first cycle after it rises, all four outputs are 0.
- R2: A pulse is a run of cycles in which `lvl_mid` or `lvl_high` is 1. The pulse must be qualified and at least ACT_US×`cyc_per_us` cycles wide. If no unbroken run of `lvl_high` within it reaches that same length, `ev_mid` is 1 for one cycle. That cycle is the one after the clock edge that samples the first low cycle following the pulse.
- R3: For a qualified pulse of sufficient width, `ev_high` replaces `ev_mid` when the longest unbroken `lvl_high` run is at least ACT_US×`cyc_per_us` cycles and below BLOW_US×`cyc_per_us` cycles.
- R4: `ev_blow` replaces `ev_high` when that run is at least BLOW_US×`cyc_per_us` cycles.
- R5: A pulse narrower than ACT_US×`cyc_per_us` cycles produces no event. A pulse of exactly that width counts.
- R6: A pulse is qualified only if at least GAP_US×`cyc_per_us` low cycles come right before its first cycle. A pulse that starts earlier produces no event, however wide it is.
- R7: Mid readings on rising and falling edges count toward the pulse width. Short `lvl_high` runs separated by mid readings are not added together: only the longest single run decides the class.
- R8: At most one of `ev_mid`, `ev_high`, `ev_blow` is 1 in any cycle, and no event lasts more than one cycle.
- R9: `sup_reset` equals `supply_ok` inverted, delayed by one cycle. When `supply_ok` is 0, the pulse in progress is dropped, and the count of quiet cycles restarts from zero.
- R10: Every threshold scales with `cyc_per_us`. The value must be held steady while out of reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| supply_ok | input | 1 | Supply present |
| lvl_mid | input | 1 | Supply at or above the mid level |
| lvl_high | input | 1 | Supply at or above the high level |
| cyc_per_us | input | CPU_W | Clock cycles per microsecond |
| ev_mid | output | 1 | One-cycle mid pulse event |
| ev_high | output | 1 | One-cycle high pulse event |
| ev_blow | output | 1 | One-cycle blow pulse event |
| sup_reset | output | 1 | Supply lost, downstream reset |

## Verification
The bench keeps the default microsecond parameters of 20, 20 and 90. It drives `cyc_per_us` at 2, then resets and drives it at 3, so that the active, gap and blow limits fall at 40/40/180 cycles and then at 60/60/270 cycles.

These small scales bring every boundary within a few hundred cycles:
- widths of one cycle below the minimum and exactly at it;
- gaps of 39 and 40 cycles;
- high holds of 179 and 180 cycles;
- a supply drop in the middle of a pulse.

// File: rtl/spc_pkg.sv
package spc_pkg;

  // Class of a finished pulse; EVK_NONE means discarded or still running.
  typedef enum logic [1:0] {
    EVK_NONE = 2'd0,
    EVK_MID  = 2'd1,
    EVK_HIGH = 2'd2,
    EVK_BLOW = 2'd3
  } evk_e;

  // Decide the class of a pulse once it has ended.
  function automatic evk_e pick_kind(input logic wide_ok, input logic qual,
                                     input logic hi_ok, input logic blow_ok);
    if (!(wide_ok && qual)) return EVK_NONE;
    if (blow_ok) return EVK_BLOW;
    if (hi_ok) return EVK_HIGH;
    return EVK_MID;
  endfunction

endpackage

// File: rtl/spc_run_ctr.sv
// Saturating run-length counter: clear has priority over increment.
module spc_run_ctr #(
  parameter int unsigned W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         inc,
  output logic [W-1:0] cnt
);

  localparam logic [W-1:0] TOP = '1;

  always_ff @(posedge clk) begin
    if (!rst_n)                  cnt <= '0;
    else if (clr)                cnt <= '0;
    else if (inc && cnt != TOP)  cnt <= cnt + 1'b1;
  end

endmodule

// File: rtl/spc_classify.sv
// Tracks one pulse at a time and names it on the cycle it ends.
module spc_classify
  import spc_pkg::*;
#(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             loss,
  input  logic             active,
  input  logic [CNT_W-1:0] gap_cnt,
  input  logic [CNT_W-1:0] width_cnt,
  input  logic [CNT_W-1:0] hrun_cnt,
  input  logic [CNT_W-1:0] act_cyc,
  input  logic [CNT_W-1:0] gap_cyc,
  input  logic [CNT_W-1:0] blow_cyc,
  output evk_e             kind,
  output logic             pulse_end,
  output logic             pulse_qual,
  output logic             blow_hit
);

  logic in_pulse;
  logic hi_flag;
  logic blow_flag;
  logic pulse_start;
  logic gap_met;
  logic hi_hit;
  logic wide_ok;

  assign gap_met     = gap_cnt >= gap_cyc;
  assign pulse_start = active & ~in_pulse & ~loss;
  assign pulse_end   = ~active & in_pulse & ~loss;

  // The counters hold the run length up to the previous cycle, so the
  // sticky flags are merged with a live compare.
  assign hi_hit   = hi_flag   | (hrun_cnt >= act_cyc);
  assign blow_hit = blow_flag | (hrun_cnt >= blow_cyc);
  assign wide_ok  = width_cnt >= act_cyc;

  assign kind = pulse_end ? pick_kind(wide_ok, pulse_qual, hi_hit, blow_hit)
                          : EVK_NONE;

  always_ff @(posedge clk) begin
    if (!rst_n || loss) begin
      in_pulse   <= 1'b0;
      pulse_qual <= 1'b0;
      hi_flag    <= 1'b0;
      blow_flag  <= 1'b0;
    end else begin
      in_pulse  <= active;
      if (pulse_start) pulse_qual <= gap_met;
      hi_flag   <= active ? hi_hit   : 1'b0;
      blow_flag <= active ? blow_hit : 1'b0;
    end
  end

endmodule

// File: rtl/spc_evt_out.sv
// Registers the pulse class into one-hot strobes and the supply reset.
module spc_evt_out
  import spc_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic loss,
  input  evk_e kind,
  output logic ev_mid,
  output logic ev_high,
  output logic ev_blow,
  output logic sup_reset
);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ev_mid    <= 1'b0;
      ev_high   <= 1'b0;
      ev_blow   <= 1'b0;
      sup_reset <= 1'b0;
    end else begin
      ev_mid    <= (kind == EVK_MID);
      ev_high   <= (kind == EVK_HIGH);
      ev_blow   <= (kind == EVK_BLOW);
      sup_reset <= loss;
    end
  end

endmodule

// File: rtl/supply_pulse_classifier.sv
module supply_pulse_classifier
  import spc_pkg::*;
#(
  parameter int unsigned CPU_W   = 8,
  parameter int unsigned CNT_W   = 16,
  parameter int unsigned ACT_US  = 20,
  parameter int unsigned GAP_US  = 20,
  parameter int unsigned BLOW_US = 90
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             supply_ok,
  input  logic             lvl_mid,
  input  logic             lvl_high,
  input  logic [CPU_W-1:0] cyc_per_us,
  output logic             ev_mid,
  output logic             ev_high,
  output logic             ev_blow,
  output logic             sup_reset
);

  localparam int unsigned NTHR = 3;
  localparam int unsigned NCTR = 3;
  localparam int unsigned T_ACT = 0, T_GAP = 1, T_BLOW = 2;
  localparam int unsigned C_GAP = 0, C_WID = 1, C_HRUN = 2;
  localparam int unsigned US_TAB [NTHR] = '{ACT_US, GAP_US, BLOW_US};
  localparam logic [63:0] CNT_MAX = 64'((64'd1 << CNT_W) - 1);

  // Microseconds to cycles, clipped at the counter ceiling.
  function automatic logic [CNT_W-1:0] to_cyc(input int unsigned us,
                                              input logic [CPU_W-1:0] cpu);
    logic [63:0] prod;
    prod = 64'(us) * 64'(cpu);
    if (prod > CNT_MAX) return '1;
    return prod[CNT_W-1:0];
  endfunction

  logic             loss;
  logic             active;
  logic [CNT_W-1:0] thr     [NTHR];
  logic [CNT_W-1:0] ctr_val [NCTR];
  logic [NCTR-1:0]  ctr_clr;
  logic [NCTR-1:0]  ctr_inc;

  // Named internal events, watched by the bound checker.
  evk_e kind;
  logic pulse_end;
  logic pulse_qual;
  logic blow_hit;

  assign loss   = ~supply_ok;
  assign active = lvl_mid | lvl_high;

  for (genvar t = 0; t < NTHR; t++) begin : g_thr
    assign thr[t] = to_cyc(US_TAB[t], cyc_per_us);
  end

  // Quiet run, pulse width, unbroken high run.
  assign ctr_clr[C_GAP]  = active | loss;
  assign ctr_inc[C_GAP]  = ~active;
  assign ctr_clr[C_WID]  = ~active | loss;
  assign ctr_inc[C_WID]  = active;
  assign ctr_clr[C_HRUN] = ~lvl_high | loss;
  assign ctr_inc[C_HRUN] = lvl_high;

  for (genvar c = 0; c < NCTR; c++) begin : g_ctr
    spc_run_ctr #(.W(CNT_W)) ctr_i (
      .clk   (clk),
      .rst_n (rst_n),
      .clr   (ctr_clr[c]),
      .inc   (ctr_inc[c]),
      .cnt   (ctr_val[c])
    );
  end

  spc_classify #(.CNT_W(CNT_W)) cls_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .loss       (loss),
    .active     (active),
    .gap_cnt    (ctr_val[C_GAP]),
    .width_cnt  (ctr_val[C_WID]),
    .hrun_cnt   (ctr_val[C_HRUN]),
    .act_cyc    (thr[T_ACT]),
    .gap_cyc    (thr[T_GAP]),
    .blow_cyc   (thr[T_BLOW]),
    .kind       (kind),
    .pulse_end  (pulse_end),
    .pulse_qual (pulse_qual),
    .blow_hit   (blow_hit)
  );

  spc_evt_out out_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .loss      (loss),
    .kind      (kind),
    .ev_mid    (ev_mid),
    .ev_high   (ev_high),
    .ev_blow   (ev_blow),
    .sup_reset (sup_reset)
  );

endmodule

// File: rtl/spc_checker.sv
module spc_checker (
  input logic clk,
  input logic rst_n,
  input logic supply_ok,
  input logic lvl_mid,
  input logic lvl_high,
  input logic ev_mid,
  input logic ev_high,
  input logic ev_blow,
  input logic sup_reset,
  input logic pulse_end,
  input logic pulse_qual,
  input logic blow_hit
);

  logic ev_any;
  assign ev_any = ev_mid | ev_high | ev_blow;

  assert_events_onehot_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({ev_mid, ev_high, ev_blow}));

  assert_event_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ev_any |=> !ev_any);

  assert_event_on_fall_R2: assert property (@(posedge clk) disable iff (!rst_n)
    ev_any |-> $past(!(lvl_mid || lvl_high) && supply_ok));

  assert_loss_flag_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !supply_ok |=> sup_reset);

  assert_loss_release_R9: assert property (@(posedge clk) disable iff (!rst_n)
    supply_ok |=> !sup_reset);

  assert_gap_discard_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (pulse_end && !pulse_qual) |=> !ev_any);

  assert_blow_source_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ev_blow |-> $past(blow_hit && pulse_end));

endmodule

bind supply_pulse_classifier spc_checker chk_i (
  .clk        (clk),
  .rst_n      (rst_n),
  .supply_ok  (supply_ok),
  .lvl_mid    (lvl_mid),
  .lvl_high   (lvl_high),
  .ev_mid     (ev_mid),
  .ev_high    (ev_high),
  .ev_blow    (ev_blow),
  .sup_reset  (sup_reset),
  .pulse_end  (pulse_end),
  .pulse_qual (pulse_qual),
  .blow_hit   (blow_hit)
);

// File: tb/supply_pulse_classifier_tb.sv
`timescale 1ns/1ps
module supply_pulse_classifier_tb_top;

  localparam int ACT_US = 20, GAP_US = 20, BLOW_US = 90;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       supply_ok = 1'b1;
  logic       lvl_mid = 1'b0;
  logic       lvl_high = 1'b0;
  logic [7:0] cyc_per_us = 8'd2;
  logic       ev_mid, ev_high, ev_blow, sup_reset;

  always #5 clk = ~clk;

  supply_pulse_classifier #(
    .CPU_W(8), .CNT_W(16), .ACT_US(ACT_US), .GAP_US(GAP_US), .BLOW_US(BLOW_US)
  ) dut_i (
    .clk(clk), .rst_n(rst_n), .supply_ok(supply_ok), .lvl_mid(lvl_mid),
    .lvl_high(lvl_high), .cyc_per_us(cyc_per_us), .ev_mid(ev_mid),
    .ev_high(ev_high), .ev_blow(ev_blow), .sup_reset(sup_reset)
  );

  int    n_cmp = 0, n_bad = 0;
  int    n_m = 0, n_h = 0, n_b = 0;
  string tag = "R1";
  logic  prev_any = 1'b0;

  // Behavioural reference: lengths kept as plain integers.
  int   lowrun, width, hrun, hbest;
  bit   inp, qual;
  logic x_mid = 0, x_high = 0, x_blow = 0, x_sr = 0;

  always @(posedge clk) begin
    int act, gap, blw;
    act = ACT_US * cyc_per_us;
    gap = GAP_US * cyc_per_us;
    blw = BLOW_US * cyc_per_us;
    x_mid = 0; x_high = 0; x_blow = 0;
    if (!rst_n || !supply_ok) begin
      lowrun = 0; width = 0; hrun = 0; hbest = 0; inp = 0; qual = 0;
      x_sr = rst_n && !supply_ok;
    end else begin
      x_sr = 0;
      if (lvl_mid || lvl_high) begin
        if (!inp) begin
          inp = 1; qual = (lowrun >= gap); width = 0; hrun = 0; hbest = 0;
        end
        width++;
        hrun = lvl_high ? hrun + 1 : 0;
        if (hrun > hbest) hbest = hrun;
        lowrun = 0;
      end else begin
        if (inp && qual && width >= act) begin
          if (hbest >= blw)      x_blow = 1;
          else if (hbest >= act) x_high = 1;
          else                   x_mid = 1;
        end
        inp = 0;
        lowrun++;
      end
    end
  end

  // Compare every cycle away from the active edge.
  always @(negedge clk) begin
    n_cmp++;
    if ({ev_mid, ev_high, ev_blow, sup_reset} !== {x_mid, x_high, x_blow, x_sr}) begin
      n_bad++;
      $display("FAIL %s t=%0t actual=%b expected=%b", tag, $time,
               {ev_mid, ev_high, ev_blow, sup_reset}, {x_mid, x_high, x_blow, x_sr});
    end
    if (ev_mid || ev_high || ev_blow) begin
      n_cmp++;
      if (!$onehot({ev_mid, ev_high, ev_blow}) || prev_any) begin
        n_bad++;
        $display("FAIL R8 t=%0t actual=%b prev=%b expected onehot, prev=0", $time,
                 {ev_mid, ev_high, ev_blow}, prev_any);
      end
    end
    prev_any = ev_mid | ev_high | ev_blow;
    n_m += int'(ev_mid); n_h += int'(ev_high); n_b += int'(ev_blow);
  end

  // lvl: 0 low, 1 mid, 2 high, 3 supply absent
  task automatic seg(input int lvl, input int n);
    for (int i = 0; i < n; i++) begin
      supply_ok = (lvl != 3);
      lvl_mid   = (lvl == 1) || (lvl == 2);
      lvl_high  = (lvl == 2);
      @(negedge clk);
    end
  endtask

  task automatic expect_ev(input int m, input int h, input int b, input string r);
    n_cmp++;
    if (n_m != m || n_h != h || n_b != b) begin
      n_bad++;
      $display("FAIL %s events actual=%0d/%0d/%0d expected=%0d/%0d/%0d",
               r, n_m, n_h, n_b, m, h, b);
    end
    n_m = 0; n_h = 0; n_b = 0;
  endtask

  task automatic check_bit(input logic act, input logic exp, input string r);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%b expected=%b", r, act, exp);
    end
  endtask

  task automatic do_reset(input logic [7:0] cpu);
    rst_n = 1'b0; cyc_per_us = cpu;
    repeat (3) @(negedge clk);
    check_bit(ev_mid | ev_high | ev_blow | sup_reset, 1'b0, "R1");
    rst_n = 1'b1;
    @(negedge clk);
    check_bit(ev_mid | ev_high | ev_blow | sup_reset, 1'b0, "R1");
    n_m = 0; n_h = 0; n_b = 0;
  endtask

  bit done = 0;

  initial begin
    #(200000 * 10);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    do_reset(8'd2);                       // act 40, gap 40, blow 180
    seg(0, 50);
    tag = "R2"; seg(1, 50); seg(0, 50); expect_ev(1, 0, 0, "R2");
    tag = "R3"; seg(1, 3); seg(2, 50); seg(1, 3); seg(0, 50); expect_ev(0, 1, 0, "R3");
    tag = "R4"; seg(2, 185); seg(0, 50); expect_ev(0, 0, 1, "R4");
    seg(2, 179); seg(0, 50); expect_ev(0, 1, 0, "R4");
    seg(2, 180); seg(0, 50); expect_ev(0, 0, 1, "R4");
    tag = "R5"; seg(1, 39); seg(0, 50); expect_ev(0, 0, 0, "R5");
    seg(1, 40); seg(0, 50); expect_ev(1, 0, 0, "R5");
    tag = "R6"; seg(1, 50); seg(0, 39); seg(1, 60); seg(0, 40); seg(1, 45); seg(0, 50);
    expect_ev(2, 0, 0, "R6");
    tag = "R7"; seg(1, 2); seg(2, 30); seg(1, 5); seg(2, 39); seg(1, 3); seg(0, 50);
    expect_ev(1, 0, 0, "R7");
    seg(1, 5); seg(2, 40); seg(1, 5); seg(0, 50); expect_ev(0, 1, 0, "R7");
    tag = "R9"; seg(1, 30); seg(3, 5);
    check_bit(sup_reset, 1'b1, "R9");
    seg(0, 20);
    check_bit(sup_reset, 1'b0, "R9");
    seg(1, 50); seg(0, 40); seg(1, 50); seg(0, 50); expect_ev(1, 0, 0, "R9");
    tag = "R10"; do_reset(8'd3);          // act 60, gap 60, blow 270
    seg(0, 70);
    seg(1, 59); seg(0, 70); expect_ev(0, 0, 0, "R10");
    seg(1, 60); seg(0, 70); expect_ev(1, 0, 0, "R10");
    seg(2, 269); seg(0, 70); expect_ev(0, 1, 0, "R10");
    seg(2, 270); seg(0, 70); expect_ev(0, 0, 1, "R10");
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule